// File: doc/BRIEF.md
# Memory-Mapped Serial Port Controller

This block is one asynchronous serial port behind a 32-bit register interface. Software enables the port and queues bytes for sending by writing a data register. Bytes that arrive on the receive line are read back one at a time from a second register. A status word and a fill-level word can be polled at any time. Both directions use 8N1 frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit.

Both directions keep a FIFO of 32 bytes. The serial logic moves one bit for each pulse on `baud_tick`. That input comes from a clock generator outside the block and pulses once per bit period. The block decodes only the low seven address bits, so its 128-byte register set repeats across the whole port window. Offsets that are not listed below read as zero and ignore writes.

Register offsets, with the address taken modulo 0x80:

- 0x04: enable.
- 0x28: status.
- 0x68: receive level.
- 0x70: transmit data.
- 0x78: receive data.

Top module: `uart_port_ctrl`

## Requirements
- R1: Only `bus_addr[6:0]` selects a register. Any address whose low seven bits match an offset accesses that register.
- R2: Offset 0x04 holds the port enable in bit 0. A write loads the enable from `bus_wdata[0]`, and a read returns the enable in bit 0 with every other bit zero. The enable is 0 after reset.
- R3: A write to offset 0x70 while the port is enabled queues `bus_wdata[7:0]`. Queued bytes are sent in write order on `tx_out` as 8N1 frames, one bit per `baud_tick`, with the start bit low, data LSB first and the stop bit high. `tx_out` idles high.
- R4: A write to offset 0x70 while the transmit FIFO holds 32 bytes is dropped. Status bit 8 is 1 exactly when the transmit FIFO is not full.
- R5: Status bit 9 (ready) is 1 only when all three hold: the port is enabled, no frame is being shifted out, and the transmit FIFO is empty. All other status bits read 0.
- R6: While the port is enabled, the receiver samples `rx_in` on each `baud_tick`. A low sample in idle starts a frame, the next eight samples are the data bits (LSB first), and the tenth sample is the stop bit. The byte is queued only if the stop sample is high. A low stop sample discards the byte.
- R7: A read of offset 0x78 returns the oldest received byte in bits 7:0 and removes it from the FIFO. A read while the receive FIFO is empty returns zero and leaves the FIFO unchanged.
- R8: Offset 0x68 returns the number of bytes in the receive FIFO in bits 5:0, from 0 to 32, with bits 31:6 zero. A byte that completes while the FIFO holds 32 is dropped.
- R9: While the port is disabled:
  - Both FIFOs are empty.
  - `tx_out` is high from the cycle after the disabling write.
  - Writes to offset 0x70 are ignored.
  - Traffic on `rx_in` is ignored.
- R10: Reads of any offset other than 0x04, 0x28, 0x68 and 0x78 return zero. Writes to any offset other than 0x04 and 0x70 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address within the port window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a pop at offset 0x78 takes effect at the clock edge |
| bus_rdata | output | 32 | Read data, combinational from the address and current state |
| baud_tick | input | 1 | One-cycle pulse, once per bit period |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |

## Verification
The transmitter is driven with the following patterns:

- A single isolated byte.
- All-zero, all-one and mixed bytes.
- A byte whose upper write-data bits are set.
- A burst of 34 back-to-back writes.

Together these separate four failures: wrong bit order, a stuck or inverted line, use of the wrong write-data lane, and an overflow that overwrites data instead of dropping the write.

The receiver is driven with these frames:

- A valid frame.
- A frame with a bad stop bit.
- 33 frames in a row, which fills the receive FIFO.
- Frames sent while the port is disabled.

These show whether the stop bit is checked, whether the level saturates at 32, and whether the disable really blocks input. Aliased addresses and unused offsets show that decoding uses only the low seven address bits. A disable in the middle of a frame shows the flush of both FIFOs and the return of the line to idle.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;
    localparam int DEC_W     = 7;
    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = DATA_W + 2;

    localparam logic [DEC_W-1:0] OFS_ENABLE = 7'h04;
    localparam logic [DEC_W-1:0] OFS_STATUS = 7'h28;
    localparam logic [DEC_W-1:0] OFS_RXLVL  = 7'h68;
    localparam logic [DEC_W-1:0] OFS_TXDATA = 7'h70;
    localparam logic [DEC_W-1:0] OFS_RXDATA = 7'h78;

    localparam int ST_TX_NOT_FULL = 8;
    localparam int ST_READY       = 9;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_DATA,
        RXS_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_port_fifo.sv
module uart_port_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign level = st_q.cnt;
    assign head  = st_q.mem[st_q.rd_ptr];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr_ptr] = wdata;
                st_d.wr_ptr           = step(st_q.wr_ptr);
            end
            if (do_pop) begin
                st_d.rd_ptr = step(st_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_port_tx.sv
module uart_port_tx
    import uart_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    output logic              take,
    output logic              busy,
    output logic              line
);
    localparam int CW = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic                 busy;
        logic [FRAME_LEN-1:0] shreg;
        logic [CW-1:0]        cnt;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (!en) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (tick) begin
                st_d.shreg = {1'b1, st_q.shreg[FRAME_LEN-1:1]};
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(FRAME_LEN - 1)) st_d.busy = 1'b0;
            end
        end else if (have_data) begin
            take       = 1'b1;
            st_d.busy  = 1'b1;
            st_d.shreg = {1'b1, data, 1'b0};
            st_d.cnt   = '0;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_port_rx.sv
module uart_port_rx
    import uart_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              line,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int CW = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         st;
        logic [DATA_W-1:0] shreg;
        logic [CW-1:0]     cnt;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        valid = 1'b0;
        if (!en) begin
            st_d.st = RXS_IDLE;
        end else if (tick) begin
            case (st_q.st)
                RXS_IDLE: begin
                    if (!line) begin
                        st_d.st  = RXS_DATA;
                        st_d.cnt = '0;
                    end
                end
                RXS_DATA: begin
                    st_d.shreg = {line, st_q.shreg[DATA_W-1:1]};
                    st_d.cnt   = st_q.cnt + 1'b1;
                    if (st_q.cnt == CW'(DATA_W - 1)) st_d.st = RXS_STOP;
                end
                RXS_STOP: begin
                    valid   = line;
                    st_d.st = RXS_IDLE;
                end
                default: st_d.st = RXS_IDLE;
            endcase
        end
    end

    assign data = st_q.shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{st: RXS_IDLE, shreg: '0, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_port_ctrl.sv
module uart_port_ctrl
    import uart_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int ADDR_W     = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              baud_tick,
    input  logic              rx_in,
    output logic              tx_out
);
    typedef struct packed {
        logic en;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [DEC_W-1:0]  bus_ofs;
    logic              port_en;
    logic              tx_push, tx_take, tx_full, tx_empty, tx_busy;
    logic [DATA_W-1:0] tx_head;
    logic [CNT_W-1:0]  tx_level, rx_level;
    logic              rx_valid, rx_pop, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_byte, rx_head;
    logic              port_ready;
    logic              unused_bits;

    assign bus_ofs     = bus_addr[DEC_W-1:0];
    assign port_en     = ctrl_q.en;
    assign unused_bits = ^{bus_addr[ADDR_W-1:DEC_W], bus_wdata[31:DATA_W], rx_full};

    assign tx_push    = bus_wr && (bus_ofs == OFS_TXDATA) && port_en;
    assign rx_pop     = bus_rd && (bus_ofs == OFS_RXDATA);
    assign port_ready = port_en && !tx_busy && tx_empty;

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_wr && (bus_ofs == OFS_ENABLE)) ctrl_d.en = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_ofs)
            OFS_ENABLE: bus_rdata[0] = port_en;
            OFS_STATUS: begin
                bus_rdata[ST_TX_NOT_FULL] = !tx_full;
                bus_rdata[ST_READY]       = port_ready;
            end
            OFS_RXLVL:  bus_rdata[CNT_W-1:0]  = rx_level;
            OFS_RXDATA: bus_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
            default:    bus_rdata = '0;
        endcase
    end

    uart_port_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!port_en),
        .push  (tx_push),
        .wdata (bus_wdata[DATA_W-1:0]),
        .pop   (tx_take),
        .head  (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uart_port_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!port_en),
        .push  (rx_valid),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .head  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_port_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (port_en),
        .tick      (baud_tick),
        .have_data (!tx_empty),
        .data      (tx_head),
        .take      (tx_take),
        .busy      (tx_busy),
        .line      (tx_out)
    );

    uart_port_rx u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (port_en),
        .tick  (baud_tick),
        .line  (rx_in),
        .valid (rx_valid),
        .data  (rx_byte)
    );
endmodule

// File: rtl/uart_port_chk.sv
module uart_port_chk
    import uart_port_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tx_line,
    input logic             tx_busy,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic             rd,
    input logic [DEC_W-1:0] ofs,
    input logic [31:0]      rdata
);
    // R9
    idle_line_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> tx_line);

    // R8
    rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH));

    // R4
    tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(DEPTH));

    // R4
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ofs == OFS_STATUS && tx_cnt == CNT_W'(DEPTH)) |-> !rdata[ST_TX_NOT_FULL]);

    // R5
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ofs == OFS_STATUS && tx_busy) |-> !rdata[ST_READY]);

    // R7
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ofs == OFS_RXDATA && rx_cnt == '0) |-> (rdata == 32'h0));

    // R7
    empty_pop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd && ofs == OFS_RXDATA && rx_cnt == '0) |=> (rx_cnt <= 1));

    // R9
    flushed_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tx_cnt == '0 && rx_cnt == '0) || en);
endmodule

bind uart_port_ctrl uart_port_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (port_en),
    .tx_line (tx_out),
    .tx_busy (tx_busy),
    .tx_cnt  (tx_level),
    .rx_cnt  (rx_level),
    .rd      (bus_rd),
    .ofs     (bus_ofs),
    .rdata   (bus_rdata)
);

// File: tb/uart_port_ctrl_tb.sv
module uart_port_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        baud_tick = 1'b0;
    logic        rx_in = 1'b1;
    logic        tx_out;

    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] exp_q[$];
    bit   mon_on = 1'b1;
    bit   finished = 1'b0;
    int   div = 0;
    logic [31:0] rv;

    uart_port_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .baud_tick (baud_tick),
        .rx_in     (rx_in),
        .tx_out    (tx_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div       <= (div == 3) ? 0 : div + 1;
        baud_tick <= (div == 3);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: decodes frames on tx_out and pops the scoreboard.
    int         m_state = 0;
    int         m_bit = 0;
    logic [7:0] m_byte = '0;
    always @(negedge clk) begin
        if (!mon_on || !rst_n) begin
            m_state = 0;
        end else if (baud_tick) begin
            case (m_state)
                0: if (!tx_out) begin m_state = 1; m_bit = 0; end
                1: begin
                    m_byte[m_bit] = tx_out;
                    m_bit++;
                    if (m_bit == 8) m_state = 2;
                end
                default: begin
                    check("R3 stop bit", {31'b0, tx_out}, 32'h1);
                    if (exp_q.size() == 0) begin
                        check("R3/R9 unexpected frame", {24'b0, m_byte}, 32'hFFFF_FFFF);
                    end else begin
                        check("R3 frame data", {24'b0, m_byte}, {24'b0, exp_q.pop_front()});
                    end
                    m_state = 0;
                end
            endcase
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_tx(input logic [15:0] a, input logic [31:0] d);
        exp_q.push_back(d[7:0]);
        bus_write(a, d);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || m_state != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_bit);
        logic [9:0] fr;
        fr = {stop_bit, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            while (!baud_tick) @(negedge clk);
            rx_in = fr[i];
            @(negedge clk);
        end
        rx_in = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        bus_read(16'h0004, rv); check("R2 enable after reset", rv, 32'h0);
        bus_read(16'h0028, rv); check("R5 status after reset", rv, 32'h100);
        bus_read(16'h0068, rv); check("R8 level after reset", rv, 32'h0);

        // R9: write while disabled is ignored (monitor flags any frame)
        bus_write(16'h0070, 32'h77);
        bus_write(16'h0004, 32'h1);
        bus_read(16'h0004, rv); check("R2 enable readback", rv, 32'h1);
        bus_read(16'h0028, rv); check("R5 status idle enabled", rv, 32'h300);
        repeat (80) @(negedge clk);
        check("R9 disabled write not sent", {31'b0, tx_out}, 32'h1);

        // R3: single byte and patterns
        send_tx(16'h0070, 32'hA5);
        bus_read(16'h0028, rv); check("R5 not ready while sending", rv, 32'h100);
        drain();
        bus_read(16'h0028, rv); check("R5 ready after drain", rv, 32'h300);
        send_tx(16'h0070, 32'h00);
        send_tx(16'h0070, 32'hFF);
        send_tx(16'h0070, 32'h3C);
        send_tx(16'h4070, 32'hFFFF_FFC3); // R1 alias, R3 low byte only
        drain();

        // R4: overflow of transmit FIFO
        for (int i = 0; i < 34; i++) begin
            if (i < 33) send_tx(16'h0070, i);
            else        bus_write(16'h0070, i);
        end
        bus_read(16'h0028, rv); check("R4 full clears not-full bit", rv, 32'h0);
        drain();

        // R6/R7/R8: receive
        send_rx(8'h5A, 1'b1);
        bus_read(16'h0068, rv); check("R8 level one", rv, 32'h1);
        bus_read(16'h0078, rv); check("R7 pop data", rv, 32'h5A);
        bus_read(16'h0068, rv); check("R7 level after pop", rv, 32'h0);
        bus_read(16'h0078, rv); check("R7 empty read zero", rv, 32'h0);
        bus_read(16'h0068, rv); check("R7 empty read keeps level", rv, 32'h0);
        send_rx(8'h81, 1'b0);
        repeat (8) @(negedge clk);
        bus_read(16'h0068, rv); check("R6 bad stop discarded", rv, 32'h0);
        send_rx(8'h96, 1'b1);
        bus_read(16'h0078, rv); check("R6 frame after bad stop", rv, 32'h96);

        // R1 aliasing
        send_rx(8'h11, 1'b1);
        bus_read(16'h1268, rv); check("R1 aliased level", rv, 32'h1);
        bus_read(16'hF878, rv); check("R1 aliased pop", rv, 32'h11);
        bus_read(16'hF828, rv); check("R1 aliased status", rv, 32'h300);
        bus_write(16'hFF84, 32'h1);
        bus_read(16'h0004, rv); check("R1 aliased enable", rv, 32'h1);

        // R10 unused offsets
        bus_write(16'h0010, 32'hFFFF_FFFF);
        bus_write(16'h0054, 32'h0000_077F);
        bus_read(16'h0010, rv); check("R10 unused read zero", rv, 32'h0);
        bus_read(16'h007C, rv); check("R10 unused read zero 7C", rv, 32'h0);
        bus_read(16'h0028, rv); check("R10 write had no effect", rv, 32'h300);
        bus_read(16'h0004, rv); check("R10 enable untouched", rv, 32'h1);

        // R8 receive FIFO full
        for (int i = 0; i < 33; i++) send_rx(8'h40 + 8'(i), 1'b1);
        bus_read(16'h0068, rv); check("R8 level saturates at 32", rv, 32'd32);
        for (int i = 0; i < 32; i++) begin
            bus_read(16'h0078, rv); check("R8 ordered pop", rv, 32'h40 + i);
        end
        bus_read(16'h0068, rv); check("R8 33rd byte dropped", rv, 32'h0);

        // R9 flush on disable
        send_rx(8'h21, 1'b1);
        send_rx(8'h22, 1'b1);
        bus_read(16'h0068, rv); check("R9 level before disable", rv, 32'h2);
        mon_on = 1'b0;
        bus_write(16'h0070, 32'h55);
        bus_write(16'h0070, 32'h66);
        bus_write(16'h0070, 32'h0F);
        repeat (13) @(negedge clk);
        bus_write(16'h0004, 32'h0);
        @(negedge clk);
        check("R9 line idle after disable", {31'b0, tx_out}, 32'h1);
        bus_read(16'h0028, rv); check("R9 status disabled", rv, 32'h100);
        bus_read(16'h0068, rv); check("R9 rx flushed", rv, 32'h0);
        bus_read(16'h0078, rv); check("R9 rx data empty", rv, 32'h0);
        send_rx(8'h33, 1'b1);
        bus_write(16'h0004, 32'h1);
        mon_on = 1'b1;
        bus_read(16'h0068, rv); check("R9 rx ignored while off", rv, 32'h0);
        repeat (100) @(negedge clk);
        check("R9 tx flushed", exp_q.size(), 32'h0);
        check("R9 line idle after re-enable", {31'b0, tx_out}, 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule